// File: doc/BRIEF.md
# Inbound Packet Router for a PCIe Transaction Layer

This block sits on the receive side of a PCI Express transaction layer and decides, one packet at a time, where each inbound packet goes. It looks at the header that arrives on the first beat of the packet. From that header it picks one of four destinations: the application stream, the internal configuration handler, the internal message handler, or a discard path that reports an Unsupported Request.

The header is 128 bits wide and carries four doublewords on one beat. Doubleword k occupies bits [32k+31:32k]. Memory and I/O requests are matched against a small table of programmed address windows. The decision is taken on the start-of-packet beat and kept until the end-of-packet beat. Payload beats therefore follow their header either to the application or into the discard path.

Every outcome leaves the block one clock after the beat that caused it. A packet that is refused produces a one-cycle event carrying the requester ID, the tag and a non-posted flag, so that a separate completion generator can answer it. When error reporting is enabled, that event also raises a one-cycle request for an upstream error message.

Top module: `pcie_rx_router`

## Requirements
- R1: A memory request (Type field, bits [28:24] of doubleword 0, equal to 00000) or an I/O request (Type 00010) is forwarded when its address lands in an enabled window of matching space (memory or I/O). The address is doubleword 2 for a 3-doubleword header and {doubleword 2, doubleword 3} for a 4-doubleword header; Fmt bit 0 (bit 29) selects 4 doublewords and Fmt bit 1 (bit 30) marks a payload. A window matches when address AND mask equals base AND mask. The header and every payload beat appear on the application stream unchanged, one cycle after they arrive.
- R2: A memory or I/O request that hits no enabled window of its space is an Unsupported Request. None of its beats reaches the application stream.
- R3: A memory request with a 4-doubleword header whose upper 32 address bits are zero is an Unsupported Request, even when its address lies inside a window.
- R4: A message (Type 10rrr) whose code (bits [7:0] of doubleword 1) is 0x7E or 0x7F is forwarded to the application, with or without payload, in both modes.
- R5: A Type 0 configuration request (Type 00100) raises the configuration strobe only in endpoint mode (mode input low). In root-port mode it is an Unsupported Request. A Type 1 configuration request (Type 00101) is always an Unsupported Request. Neither is ever forwarded.
- R6: Messages with codes 0x14, 0x18, 0x19, 0x1B (power management) and 0x50 (slot power limit) raise the message-handled strobe in both modes and are not forwarded.
- R7: In endpoint mode, code 0x00 (unlock) raises the message-handled strobe. In root-port mode, codes 0x20 to 0x27 (interrupt) and 0x30, 0x31, 0x33 (error) raise it instead. Any other message code is an Unsupported Request.
- R8: Every Unsupported Request raises a one-cycle event carrying the requester ID (bits [31:16] of doubleword 1) and the tag (bits [15:8] of doubleword 1). Its non-posted flag is low for a memory write (memory with Fmt bit 1 set) and for any message, and high otherwise.
- R9: The error-message request pulses together with the Unsupported Request event exactly when error reporting is enabled.
- R10: Completions (Type 0101x) are forwarded to the application.
- R11: The decision made on the start beat holds through the end beat. Idle cycles inside a packet produce no application beat. Exactly one destination is chosen per packet.
- R12: While reset is asserted and in the cycle after its release, no output valid or strobe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rp_mode | input | 1 | 1 = root port, 0 = endpoint |
| err_msg_en | input | 1 | Enable upstream error-message requests |
| win_base | input | NUM_WIN*64 | Base address of each window |
| win_mask | input | NUM_WIN*64 | Compare mask of each window (1 = bit compared) |
| win_en | input | NUM_WIN | Window enable |
| win_is_io | input | NUM_WIN | Window is I/O space (else memory) |
| rx_valid | input | 1 | Inbound beat valid |
| rx_sop | input | 1 | Inbound start of packet |
| rx_eop | input | 1 | Inbound end of packet |
| rx_data | input | 128 | Inbound beat |
| app_valid | output | 1 | Forwarded beat valid |
| app_sop | output | 1 | Forwarded start of packet |
| app_eop | output | 1 | Forwarded end of packet |
| app_data | output | 128 | Forwarded beat |
| cfg_req_stb | output | 1 | Configuration request for internal handling |
| msg_done_stb | output | 1 | Message consumed internally |
| ur_stb | output | 1 | Unsupported Request event |
| ur_req_id | output | 16 | Requester ID of the refused request |
| ur_tag | output | 8 | Tag of the refused request |
| ur_nonposted | output | 1 | Refused request expects a completion |
| err_msg_req | output | 1 | Request to send an error message upstream |

## Verification
The only state in the block is the routing decision kept between the start beat and the end beat. If that decision is wrong, the packet's payload beats show up on the application stream where they should be missing, or go missing where they should appear. This is visible on the first payload beat, one cycle after it enters. A wrong header classification shows in the very next cycle: the wrong strobe fires, or the Unsupported Request event carries a wrong ID, tag or non-posted flag. The stimulus therefore mixes single-beat and multi-beat packets, with idle gaps inside them, across both modes and both error-enable settings. It also places addresses on every window edge and on the 4 GB line.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  localparam int HDR_W  = 128;
  localparam int ADDR_W = 64;

  typedef enum logic [1:0] {
    RT_APP = 2'd0,
    RT_CFG = 2'd1,
    RT_MSG = 2'd2,
    RT_UR  = 2'd3
  } route_e;

  localparam logic [4:0] TY_MEM  = 5'b00000;
  localparam logic [4:0] TY_IO   = 5'b00010;
  localparam logic [4:0] TY_CFG0 = 5'b00100;
  localparam logic [4:0] TY_CFG1 = 5'b00101;

  function automatic logic ty_is_msg(input logic [4:0] t);
    return t[4:3] == 2'b10;
  endfunction

  function automatic logic ty_is_cpl(input logic [4:0] t);
    return t[4:1] == 4'b0101;
  endfunction

  function automatic logic code_vendor(input logic [7:0] c);
    return c[7:1] == 7'h3F;
  endfunction

  function automatic logic code_power(input logic [7:0] c);
    return (c == 8'h14) || (c == 8'h18) || (c == 8'h19) ||
           (c == 8'h1B) || (c == 8'h50);
  endfunction

  function automatic logic code_rp_only(input logic [7:0] c);
    return (c[7:3] == 5'b00100) || (c == 8'h30) || (c == 8'h31) || (c == 8'h33);
  endfunction

  function automatic logic code_ep_only(input logic [7:0] c);
    return c == 8'h00;
  endfunction

  function automatic logic [ADDR_W-1:0] req_addr(input logic four_dw,
                                                 input logic [31:0] dw2,
                                                 input logic [31:0] dw3);
    logic [ADDR_W-1:0] a;
    if (four_dw) a = {dw2, dw3[31:2], 2'b00};
    else         a = {32'h0, dw2[31:2], 2'b00};
    return a;
  endfunction
endpackage

// File: rtl/rxr_win_match.sv
module rxr_win_match #(
  parameter int NUM_WIN = 3,
  parameter int AW      = 64
) (
  input  logic [AW-1:0]         addr,
  input  logic                  io_space,
  input  logic [NUM_WIN*AW-1:0] base,
  input  logic [NUM_WIN*AW-1:0] mask,
  input  logic [NUM_WIN-1:0]    en,
  input  logic [NUM_WIN-1:0]    is_io,
  output logic                  hit
);
  logic [NUM_WIN-1:0] hit_vec;

  generate
    for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
      logic [AW-1:0] b;
      logic [AW-1:0] m;
      assign b = base[g*AW +: AW];
      assign m = mask[g*AW +: AW];
      assign hit_vec[g] = en[g] && (is_io[g] == io_space) && ((addr & m) == (b & m));
    end
  endgenerate

  assign hit = |hit_vec;
endmodule

// File: rtl/rxr_hdr_decode.sv
module rxr_hdr_decode
  import rxr_pkg::*;
(
  input  logic [1:0] fmt,
  input  logic [4:0] typ,
  input  logic [7:0] msg_code,
  input  logic       addr_hi_zero,
  input  logic       rp_mode,
  input  logic       win_hit,
  output route_e     route,
  output logic       nonposted
);
  logic is_mem, is_io, is_cfg0, is_cfg1, is_msg, is_cpl;
  logic low_4dw;

  assign is_mem  = typ == TY_MEM;
  assign is_io   = typ == TY_IO;
  assign is_cfg0 = typ == TY_CFG0;
  assign is_cfg1 = typ == TY_CFG1;
  assign is_msg  = ty_is_msg(typ);
  assign is_cpl  = ty_is_cpl(typ);
  assign low_4dw = is_mem && fmt[0] && addr_hi_zero;

  always_comb begin
    route = RT_UR;
    if (is_mem) begin
      if (!low_4dw && win_hit) route = RT_APP;
    end else if (is_io) begin
      if (win_hit) route = RT_APP;
    end else if (is_cfg0) begin
      if (!rp_mode) route = RT_CFG;
    end else if (is_cfg1) begin
      route = RT_UR;
    end else if (is_msg) begin
      if (code_vendor(msg_code))                        route = RT_APP;
      else if (code_power(msg_code))                    route = RT_MSG;
      else if (rp_mode && code_rp_only(msg_code))       route = RT_MSG;
      else if (!rp_mode && code_ep_only(msg_code))      route = RT_MSG;
    end else if (is_cpl) begin
      route = RT_APP;
    end
  end

  assign nonposted = !(is_mem && fmt[1]) && !is_msg;

  always_comb begin
    if (low_4dw) a_r3_low_4dw_refused: assert (route == RT_UR);
  end
endmodule

// File: rtl/rxr_route_ctrl.sv
module rxr_route_ctrl
  import rxr_pkg::*;
#(
  parameter int DW = 128
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_valid,
  input  logic          rx_sop,
  input  logic          rx_eop,
  input  logic [DW-1:0] rx_data,
  input  route_e        route,
  input  logic          nonposted,
  input  logic [15:0]   req_id,
  input  logic [7:0]    tag,
  input  logic          err_msg_en,
  output logic          app_valid,
  output logic          app_sop,
  output logic          app_eop,
  output logic [DW-1:0] app_data,
  output logic          cfg_req_stb,
  output logic          msg_done_stb,
  output logic          ur_stb,
  output logic [15:0]   ur_req_id,
  output logic [7:0]    ur_tag,
  output logic          ur_nonposted,
  output logic          err_msg_req
);
  logic held_fwd;
  logic beat_fwd;
  logic head;

  assign head     = rx_valid && rx_sop;
  assign beat_fwd = rx_sop ? (route == RT_APP) : held_fwd;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held_fwd <= 1'b0;
    end else if (rx_valid) begin
      if (rx_eop)      held_fwd <= 1'b0;
      else if (rx_sop) held_fwd <= (route == RT_APP);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      app_valid    <= 1'b0;
      app_sop      <= 1'b0;
      app_eop      <= 1'b0;
      app_data     <= '0;
      cfg_req_stb  <= 1'b0;
      msg_done_stb <= 1'b0;
      ur_stb       <= 1'b0;
      ur_req_id    <= '0;
      ur_tag       <= '0;
      ur_nonposted <= 1'b0;
      err_msg_req  <= 1'b0;
    end else begin
      app_valid    <= rx_valid && beat_fwd;
      app_sop      <= rx_sop;
      app_eop      <= rx_eop;
      app_data     <= rx_data;
      cfg_req_stb  <= head && (route == RT_CFG);
      msg_done_stb <= head && (route == RT_MSG);
      ur_stb       <= head && (route == RT_UR);
      err_msg_req  <= head && (route == RT_UR) && err_msg_en;
      if (head && (route == RT_UR)) begin
        ur_req_id    <= req_id;
        ur_tag       <= tag;
        ur_nonposted <= nonposted;
      end
    end
  end

  a_r2_refused_not_forwarded: assert property (@(posedge clk) disable iff (!rst_n)
    ur_stb |-> !app_valid);

  a_r9_err_with_refusal: assert property (@(posedge clk) disable iff (!rst_n)
    err_msg_req |-> ur_stb);

  a_r11_one_destination: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({app_valid && app_sop, cfg_req_stb, msg_done_stb, ur_stb}));

  a_r11_dropped_body_stays_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_sop && !held_fwd) |=> !app_valid);

  a_r1_head_follows_input: assert property (@(posedge clk) disable iff (!rst_n)
    (app_valid && app_sop) |-> $past(rx_valid && rx_sop));
endmodule

// File: rtl/pcie_rx_router.sv
module pcie_rx_router
  import rxr_pkg::*;
#(
  parameter int NUM_WIN = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      rp_mode,
  input  logic                      err_msg_en,
  input  logic [NUM_WIN*ADDR_W-1:0] win_base,
  input  logic [NUM_WIN*ADDR_W-1:0] win_mask,
  input  logic [NUM_WIN-1:0]        win_en,
  input  logic [NUM_WIN-1:0]        win_is_io,
  input  logic                      rx_valid,
  input  logic                      rx_sop,
  input  logic                      rx_eop,
  input  logic [HDR_W-1:0]          rx_data,
  output logic                      app_valid,
  output logic                      app_sop,
  output logic                      app_eop,
  output logic [HDR_W-1:0]          app_data,
  output logic                      cfg_req_stb,
  output logic                      msg_done_stb,
  output logic                      ur_stb,
  output logic [15:0]               ur_req_id,
  output logic [7:0]                ur_tag,
  output logic                      ur_nonposted,
  output logic                      err_msg_req
);
  logic [1:0]        fmt;
  logic [4:0]        typ;
  logic [15:0]       req_id;
  logic [7:0]        tag;
  logic [7:0]        msg_code;
  logic [31:0]       dw2, dw3;
  logic [ADDR_W-1:0] addr;
  logic              req_io;
  logic              win_hit;
  logic              nonposted;
  route_e            route;

  assign fmt      = rx_data[30:29];
  assign typ      = rx_data[28:24];
  assign req_id   = rx_data[63:48];
  assign tag      = rx_data[47:40];
  assign msg_code = rx_data[39:32];
  assign dw2      = rx_data[95:64];
  assign dw3      = rx_data[127:96];
  assign addr     = req_addr(fmt[0], dw2, dw3);
  assign req_io   = typ == TY_IO;

  rxr_win_match #(.NUM_WIN(NUM_WIN), .AW(ADDR_W)) u_match (
    .addr     (addr),
    .io_space (req_io),
    .base     (win_base),
    .mask     (win_mask),
    .en       (win_en),
    .is_io    (win_is_io),
    .hit      (win_hit)
  );

  rxr_hdr_decode u_dec (
    .fmt          (fmt),
    .typ          (typ),
    .msg_code     (msg_code),
    .addr_hi_zero (addr[63:32] == 32'h0),
    .rp_mode      (rp_mode),
    .win_hit      (win_hit),
    .route        (route),
    .nonposted    (nonposted)
  );

  rxr_route_ctrl #(.DW(HDR_W)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .rx_valid     (rx_valid),
    .rx_sop       (rx_sop),
    .rx_eop       (rx_eop),
    .rx_data      (rx_data),
    .route        (route),
    .nonposted    (nonposted),
    .req_id       (req_id),
    .tag          (tag),
    .err_msg_en   (err_msg_en),
    .app_valid    (app_valid),
    .app_sop      (app_sop),
    .app_eop      (app_eop),
    .app_data     (app_data),
    .cfg_req_stb  (cfg_req_stb),
    .msg_done_stb (msg_done_stb),
    .ur_stb       (ur_stb),
    .ur_req_id    (ur_req_id),
    .ur_tag       (ur_tag),
    .ur_nonposted (ur_nonposted),
    .err_msg_req  (err_msg_req)
  );

  a_r5_cfg_endpoint_only: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req_stb |-> $past(!rp_mode));

  a_r3_low_4dw_event: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_sop && typ == TY_MEM && fmt[0] && dw2 == 32'h0) |=> ur_stb);
endmodule

// File: tb/tb_pcie_rx_router.sv
module tb_pcie_rx_router;
  localparam int CLK_PERIOD = 10;
  localparam int NW = 3;
  localparam int NPKT = 400;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rp_mode = 1'b0, err_msg_en = 1'b0;
  logic [NW*64-1:0] win_base, win_mask;
  logic [NW-1:0] win_en = '1;
  logic [NW-1:0] win_is_io;
  logic rx_valid = 1'b0, rx_sop = 1'b0, rx_eop = 1'b0;
  logic [127:0] rx_data = '0;
  logic app_valid, app_sop, app_eop;
  logic [127:0] app_data;
  logic cfg_req_stb, msg_done_stb, ur_stb, ur_nonposted, err_msg_req;
  logic [15:0] ur_req_id;
  logic [7:0] ur_tag;

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;

  logic [63:0] wb [NW];
  logic [63:0] ws [NW];
  bit          wio[NW];

  always #(CLK_PERIOD/2) clk = ~clk;

  always_comb begin
    for (int i = 0; i < NW; i++) begin
      win_base[i*64 +: 64] = wb[i];
      win_mask[i*64 +: 64] = ~(ws[i] - 64'd1);
      win_is_io[i]         = wio[i];
    end
  end

  pcie_rx_router #(.NUM_WIN(NW)) dut (
    .clk(clk), .rst_n(rst_n), .rp_mode(rp_mode), .err_msg_en(err_msg_en),
    .win_base(win_base), .win_mask(win_mask), .win_en(win_en), .win_is_io(win_is_io),
    .rx_valid(rx_valid), .rx_sop(rx_sop), .rx_eop(rx_eop), .rx_data(rx_data),
    .app_valid(app_valid), .app_sop(app_sop), .app_eop(app_eop), .app_data(app_data),
    .cfg_req_stb(cfg_req_stb), .msg_done_stb(msg_done_stb), .ur_stb(ur_stb),
    .ur_req_id(ur_req_id), .ur_tag(ur_tag), .ur_nonposted(ur_nonposted),
    .err_msg_req(err_msg_req)
  );

  task automatic chk(input bit ok, input string rq, input logic [127:0] got,
                     input logic [127:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s got=%0h exp=%0h", rq, got, exp);
    end
  endtask

  // 0 application, 1 configuration, 2 internal message, 3 refused
  function automatic int ref_route(input logic [1:0] f, input logic [4:0] t,
                                   input logic [7:0] c, input logic [63:0] a,
                                   input bit rp);
    bit hit = 0;
    bit io = (t == 5'd2);
    for (int i = 0; i < NW; i++)
      if (win_en[i] && wio[i] == io && a >= wb[i] && a < wb[i] + ws[i]) hit = 1;
    if (t == 5'd0) return (f[0] && a < 64'h1_0000_0000) ? 3 : (hit ? 0 : 3);
    if (t == 5'd2) return hit ? 0 : 3;
    if (t == 5'd4) return rp ? 3 : 1;
    if (t == 5'd5) return 3;
    if (t >= 5'd16 && t <= 5'd23) begin
      if (c == 8'h7E || c == 8'h7F) return 0;
      if (c == 8'h14 || c == 8'h18 || c == 8'h19 || c == 8'h1B || c == 8'h50) return 2;
      if (rp && ((c >= 8'h20 && c <= 8'h27) || c == 8'h30 || c == 8'h31 || c == 8'h33))
        return 2;
      if (!rp && c == 8'h00) return 2;
      return 3;
    end
    if (t == 5'd10 || t == 5'd11) return 0;
    return 3;
  endfunction

  function automatic string ref_label(input logic [1:0] f, input logic [4:0] t,
                                      input logic [7:0] c, input logic [63:0] a, input int r);
    if (t == 5'd0 && f[0] && a < 64'h1_0000_0000) return "R3";
    if (t == 5'd0 || t == 5'd2) return (r == 0) ? "R1" : "R2";
    if (t == 5'd4 || t == 5'd5) return "R5";
    if (t >= 5'd16 && t <= 5'd23) begin
      if (c == 8'h7E || c == 8'h7F) return "R4";
      if (c == 8'h14 || c == 8'h18 || c == 8'h19 || c == 8'h1B || c == 8'h50) return "R6";
      return "R7";
    end
    return "R10";
  endfunction

  task automatic idle_check();
    @(negedge clk);
    rx_valid = 1'b0; rx_sop = 1'b0; rx_eop = 1'b0;
    @(posedge clk); #1;
    chk(!app_valid && !cfg_req_stb && !msg_done_stb && !ur_stb, "R11",
        {app_valid, cfg_req_stb, msg_done_stb, ur_stb}, 0);
  endtask

  task automatic send_pkt(input logic [1:0] f, input logic [4:0] t, input logic [7:0] c,
                          input logic [63:0] a, input bit gaps);
    logic [127:0] hdr;
    logic [15:0] rid = 16'($urandom);
    logic [7:0]  tg  = 8'($urandom);
    int r = ref_route(f, t, c, a, rp_mode);
    string rq = ref_label(f, t, c, a, r);
    int nb = f[1] ? 1 + $urandom_range(1, 3) : 1;
    bit np = !(t == 5'd0 && f[1]) && !(t >= 5'd16 && t <= 5'd23);
    logic [4:0] ef, gf;
    hdr[31:0]  = {1'b0, f, t, 24'h000001};
    hdr[63:32] = {rid, tg, c};
    if (f[0]) begin hdr[95:64] = a[63:32]; hdr[127:96] = a[31:0]; end
    else      begin hdr[95:64] = a[31:0];  hdr[127:96] = $urandom; end
    for (int b = 0; b < nb; b++) begin
      logic [127:0] d = (b == 0) ? hdr : {$urandom, $urandom, $urandom, $urandom};
      if (b > 0 && gaps && $urandom_range(0, 3) == 0) idle_check();
      @(negedge clk);
      rx_valid = 1'b1; rx_sop = (b == 0); rx_eop = (b == nb - 1); rx_data = d;
      @(posedge clk); #1;
      if (b == 0) begin
        ef = {r == 0, r == 1, r == 2, r == 3, (r == 3) && err_msg_en};
        gf = {app_valid, cfg_req_stb, msg_done_stb, ur_stb, err_msg_req};
        chk(gf[4:1] == ef[4:1], rq, 128'(gf), 128'(ef));
        chk(gf[0] == ef[0], "R9", 128'(gf), 128'(ef));
        if (r == 3)
          chk({ur_req_id, ur_tag, ur_nonposted} == {rid, tg, np}, "R8",
              128'({ur_req_id, ur_tag, ur_nonposted}), 128'({rid, tg, np}));
      end else begin
        chk(app_valid == (r == 0), (r == 0) ? "R11" : "R2", 128'(app_valid), 128'(r == 0));
      end
      if (r == 0)
        chk(app_data == d && app_sop == (b == 0) && app_eop == (b == nb - 1),
            (rq == "R4" || rq == "R10") ? rq : "R1", app_data, d);
    end
    @(negedge clk);
    rx_valid = 1'b0; rx_sop = 1'b0; rx_eop = 1'b0;
  endtask

  function automatic logic [7:0] pick_code();
    logic [7:0] codes [16] = '{8'h00, 8'h14, 8'h18, 8'h19, 8'h1B, 8'h50, 8'h20, 8'h23,
                               8'h27, 8'h30, 8'h31, 8'h33, 8'h7E, 8'h7F, 8'h40, 8'h05};
    return codes[$urandom_range(0, 15)];
  endfunction

  function automatic logic [63:0] in_win(input int i);
    return wb[i] + {32'h0, ($urandom % 32'(ws[i] >> 2)), 2'b00};
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    wb[0] = 64'h8000_0000;   ws[0] = 64'h10_0000; wio[0] = 0;
    wb[1] = 64'h1_0000_0000; ws[1] = 64'h1_0000;  wio[1] = 1'b0;
    wb[2] = 64'h1000;        ws[2] = 64'h100;     wio[2] = 1;
    repeat (3) begin
      @(posedge clk); #1;
      chk(!app_valid && !cfg_req_stb && !msg_done_stb && !ur_stb && !err_msg_req, "R12",
          {app_valid, cfg_req_stb, msg_done_stb, ur_stb, err_msg_req}, 0);
    end
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    chk(!app_valid && !cfg_req_stb && !msg_done_stb && !ur_stb && !err_msg_req, "R12",
        {app_valid, cfg_req_stb, msg_done_stb, ur_stb, err_msg_req}, 0);

    for (int p = 0; p < NPKT; p++) begin
      int k = $urandom_range(0, 9);
      logic fd = 1'($urandom);
      @(negedge clk);
      rp_mode = 1'($urandom); err_msg_en = 1'($urandom);
      case (k)
        0: send_pkt({fd, 1'b0}, 5'd0, 8'h0, in_win(0), 1);
        1: send_pkt({fd, 1'b0}, 5'd0, 8'h0, {32'h0, $urandom & 32'hFFFF_FFFC}, 1);
        2: send_pkt({fd, 1'b1}, 5'd0, 8'h0, in_win(1), 1);
        3: send_pkt({fd, 1'b1}, 5'd0, 8'h0, in_win(0), 1);
        4: send_pkt({fd, 1'b0}, 5'd2, 8'h0, in_win(2), 1);
        5: send_pkt({fd, 1'b0}, 5'd2, 8'h0, in_win(0), 1);
        6: send_pkt({fd, 1'b0}, 5'($urandom_range(4, 5)), 8'h0, in_win(0), 1);
        7, 8: send_pkt({fd, 1'b1}, {2'b10, 3'($urandom)}, pick_code(), 64'h0, 1);
        default: send_pkt({fd, 1'b0}, {4'b0101, 1'($urandom)}, 8'h0, 64'h0, 1);
      endcase
    end

    // directed corners
    @(negedge clk); rp_mode = 1'b0; err_msg_en = 1'b1;
    send_pkt(2'b10, 5'd0, 8'h0, 64'h800F_FFFC, 0);          // R1 last dword of window
    send_pkt(2'b10, 5'd0, 8'h0, 64'h8010_0000, 0);          // R2 first dword past window
    send_pkt(2'b11, 5'd0, 8'h0, 64'hFFFF_FFFC, 0);          // R3 just below 4 GB
    send_pkt(2'b11, 5'd0, 8'h0, 64'h1_0000_0000, 0);        // R1 exactly at 4 GB
    send_pkt(2'b01, 5'd16, 8'h20, 64'h0, 0);                // R7 interrupt in endpoint
    send_pkt(2'b01, 5'd16, 8'h00, 64'h0, 0);                // R7 unlock in endpoint
    @(negedge clk); win_en[0] = 1'b0;
    send_pkt(2'b10, 5'd0, 8'h0, 64'h8000_0040, 0);          // R2 disabled window
    @(negedge clk); win_en[0] = 1'b1; rp_mode = 1'b1; err_msg_en = 1'b0;
    send_pkt(2'b00, 5'd4, 8'h0, 64'h0, 0);                  // R5 cfg0 in root port
    send_pkt(2'b01, 5'd16, 8'h00, 64'h0, 0);                // R7 unlock in root port
    send_pkt(2'b01, 5'd16, 8'h33, 64'h0, 0);                // R7 error in root port
    send_pkt(2'b11, 5'd16, 8'h7F, 64'h0, 0);                // R4 vendor with payload

    repeat (2) @(posedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule